// File: doc/BRIEF.md
# Cascadable Dual PWM Generator

This block produces two pulse-width modulated outputs from two 8-bit channels. Each channel has its own period and duty inputs, its own enable and its own output polarity. Inside a period the output is active while the channel counter is below the duty value. A duty of zero keeps the output inactive for the whole period. A duty at or above the period keeps it active for the whole period.

A join input fuses the two channels into one channel of twice the width. In this mode channel 0 supplies the low byte of the period and duty, and channel 1 supplies the high byte. The fused waveform leaves on output 0, and output 1 stays at its inactive level.

Period and duty are double buffered. The counters compare against shadow copies, and those copies reload only at a period boundary or while the channel is disabled. Software can therefore rewrite the inputs at any time without producing a torn pulse. Both outputs are registered.

Top module: `dual_pwm_cascade`

## Requirements
- R1: While `rst` is high, both outputs are 0 and the counters and shadow copies are cleared.
- R2: Take the edge at which the enable is first seen high as cycle 0. In split mode, after the edge of cycle k the output is active exactly when (k mod P) < D. P is the period and D is the duty (P ≥ 1, D < P).
- R3: A duty of 0 holds the output at its inactive level in every cycle.
- R4: A duty greater than or equal to the period holds the output active in every cycle.
- R5: The active level is 1 when the polarity bit is 0. The active level is 0 when the polarity bit is 1, so the waveform is inverted.
- R6: In split mode the two channels run independently, each with its own period, duty, polarity and enable.
- R7: A period or duty change made in the middle of a period takes effect only from the next period boundary.
- R8: With `join_en` high, the output on `pwm_out0` follows R2 with P = {period1, period0} and D = {duty1, duty0}, both 16 bits. The channel-1 half of the counter advances only when the channel-0 half rolls over, and the whole channel is enabled by `en0`.
- R9: With `join_en` high, `pwm_out1` is held at channel 1's inactive level, which equals `pol1`.
- R10: A low enable makes the output equal its polarity bit (the inactive level) from the next edge on. It also clears the counter, so re-enabling restarts at cycle 0 of R2.
- R11: A period of 0 or 1 makes every cycle a period boundary. The output is then active in every cycle when the duty is nonzero and inactive in every cycle when the duty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| join_en | input | 1 | 1: fuse the two channels into one double-width channel on output 0 |
| en0 | input | 1 | Channel 0 enable (also enables the fused channel) |
| pol0 | input | 1 | Channel 0 polarity, 1 inverts the output |
| period0 | input | W | Channel 0 period (low byte when fused) |
| duty0 | input | W | Channel 0 duty (low byte when fused) |
| en1 | input | 1 | Channel 1 enable (split mode only) |
| pol1 | input | 1 | Channel 1 polarity, 1 inverts the output |
| period1 | input | W | Channel 1 period (high byte when fused) |
| duty1 | input | W | Channel 1 duty (high byte when fused) |
| pwm_out0 | output | 1 | Channel 0 or fused output, registered |
| pwm_out1 | output | 1 | Channel 1 output, registered |

## Verification
The bench builds the block with the default channel width of 8. At that width the full duty range, including 255 above a short period, can be reached in a few cycles. A fused period of 300, which needs the high byte and a carry between the two counters, fits in a 600-cycle window. A period of 0 and a period of 1 are exercised to reach the degenerate boundary of R11. A mid-period rewrite of both period and duty is also exercised for R7.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_JOINED = 1'b1} mode_e;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (adv)     cnt <= cnt + 1'b1;
  end

  // R2: the count steps by one when it is neither cleared nor held
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (!clear && adv) |=> cnt == W'($past(cnt) + 1'b1));
  // R10: a clear brings the count back to zero
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt == '0);
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] per,
  output logic [W-1:0] duty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      per  <= '0;
      duty <= '0;
    end else if (load) begin
      per  <= per_in;
      duty <= duty_in;
    end
  end

  // R7: shadow copies change only at a load
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(per) && $stable(duty)));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          force_idle,
  input  logic          pol,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty,
  output logic          out
);
  always_ff @(posedge clk) begin
    if (rst)             out <= 1'b0;
    else if (force_idle) out <= pol;
    else                 out <= (cnt < duty) ^ pol;
  end

  // R10: a forced-idle channel shows its inactive level on the next edge
  a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
    force_idle |=> out == $past(pol));
  // R3: zero duty never produces an active cycle
  a_r3_zero_duty: assert property (@(posedge clk) disable iff (rst)
    (!force_idle && duty == '0) |=> out == $past(pol));
endmodule

// File: rtl/dual_pwm_cascade.sv
module dual_pwm_cascade #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         join_en,
  input  logic         en0,
  input  logic         pol0,
  input  logic [W-1:0] period0,
  input  logic [W-1:0] duty0,
  input  logic         en1,
  input  logic         pol1,
  input  logic [W-1:0] period1,
  input  logic [W-1:0] duty1,
  output logic         pwm_out0,
  output logic         pwm_out1
);
  import cpwm_pkg::*;

  localparam int NCH = 2;
  localparam int JW  = 2 * W;
  localparam logic [W:0]  ONE_S = (W+1)'(1);
  localparam logic [JW:0] ONE_J = (JW+1)'(1);

  mode_e mode;
  assign mode = join_en ? MODE_JOINED : MODE_SPLIT;

  logic [NCH-1:0]        en_v, clr, adv, ld, wrap_s;
  logic [NCH-1:0][W-1:0] cnt, sper, sdut, per_in, dut_in;
  logic                  wrap_j;
  logic [JW-1:0]         cnt_j, per_j, dut_j;

  assign en_v   = {en1, en0};
  assign per_in = {period1, period0};
  assign dut_in = {duty1, duty0};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      cpwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .clear(clr[i]), .adv(adv[i]), .cnt(cnt[i])
      );
      cpwm_shadow #(.W(W)) u_shd (
        .clk(clk), .rst(rst), .load(ld[i]),
        .per_in(per_in[i]), .duty_in(dut_in[i]),
        .per(sper[i]), .duty(sdut[i])
      );
      assign wrap_s[i] = ({1'b0, cnt[i]} + ONE_S) >= {1'b0, sper[i]};
    end
  endgenerate

  assign cnt_j  = {cnt[1], cnt[0]};
  assign per_j  = {sper[1], sper[0]};
  assign dut_j  = {sdut[1], sdut[0]};
  assign wrap_j = ({1'b0, cnt_j} + ONE_J) >= {1'b0, per_j};

  always_comb begin
    if (mode == MODE_JOINED) begin
      clr = {2{~en0 | wrap_j}};
      ld  = clr;
      adv = {&cnt[0], 1'b1};
    end else begin
      clr = ~en_v | wrap_s;
      ld  = clr;
      adv = '1;
    end
  end

  logic [JW-1:0] cmp_cnt0, cmp_dut0;
  assign cmp_cnt0 = (mode == MODE_JOINED) ? cnt_j : {{W{1'b0}}, cnt[0]};
  assign cmp_dut0 = (mode == MODE_JOINED) ? dut_j : {{W{1'b0}}, sdut[0]};

  cpwm_compare #(.CW(JW)) u_cmp0 (
    .clk(clk), .rst(rst), .force_idle(~en0), .pol(pol0),
    .cnt(cmp_cnt0), .duty(cmp_dut0), .out(pwm_out0)
  );

  cpwm_compare #(.CW(W)) u_cmp1 (
    .clk(clk), .rst(rst), .force_idle(~en1 | (mode == MODE_JOINED)), .pol(pol1),
    .cnt(cnt[1]), .duty(sdut[1]), .out(pwm_out1)
  );

  // R9: fused mode keeps output 1 at its inactive level
  a_r9_joined_out1_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_JOINED) |=> pwm_out1 == $past(pol1));
  // R8: in fused mode both halves restart together
  a_r8_joined_restart: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_JOINED && (~en0 | wrap_j)) |=> (cnt[0] == '0 && cnt[1] == '0));
  // R1: outputs low throughout reset
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (pwm_out0 == 1'b0 && pwm_out1 == 1'b0));
endmodule

// File: tb/sim_dual_pwm_cascade.sv
module sim_dual_pwm_cascade;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic join_en = 0, en0 = 0, pol0 = 0, en1 = 0, pol1 = 0;
  logic [W-1:0] period0 = '0, duty0 = '0, period1 = '0, duty1 = '0;
  logic pwm_out0, pwm_out1;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_pwm_cascade #(.W(W)) u0 (
    .clk(clk), .rst(rst), .join_en(join_en),
    .en0(en0), .pol0(pol0), .period0(period0), .duty0(duty0),
    .en1(en1), .pol1(pol1), .period1(period1), .duty1(duty1),
    .pwm_out0(pwm_out0), .pwm_out1(pwm_out1)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic logic expect_out(input int k, input int p, input int d, input logic pol);
    int per = (p < 1) ? 1 : p;
    return ((k % per) < d) ^ pol;
  endfunction

  // idle channel 0 with config, then enable; returns right after edge of cycle 0
  task automatic start0(input int p, input int d, input logic pol);
    @(negedge clk);
    en0 = 0; period0 = W'(p); duty0 = W'(d); pol0 = pol;
    repeat (2) @(negedge clk);
    en0 = 1;
    @(negedge clk);
  endtask

  task automatic run0(input int p, input int d, input logic pol, input int n, input string req);
    start0(p, d, pol);
    for (int k = 0; k < n; k++) begin
      check(pwm_out0, expect_out(k, p, d, pol), req, $sformatf("cycle %0d P=%0d D=%0d", k, p, d));
      @(negedge clk);
    end
    en0 = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    check(pwm_out0, 1'b0, "R1", "out0 in reset");
    check(pwm_out1, 1'b0, "R1", "out1 in reset");
    rst = 0;
    pol1 = 1;
    repeat (2) @(negedge clk);
    check(pwm_out0, 1'b0, "R10", "out0 disabled pol0=0");
    check(pwm_out1, 1'b1, "R10", "out1 disabled pol1=1");
    pol1 = 0;
  endtask

  task automatic t_basic;    run0(10, 3, 1'b0, 20, "R2");  endtask
  task automatic t_zero;     run0(6, 0, 1'b0, 12, "R3");   endtask
  task automatic t_full;
    run0(5, 5, 1'b0, 10, "R4");
    run0(5, 255, 1'b0, 10, "R4");
  endtask
  task automatic t_pol;      run0(8, 2, 1'b1, 16, "R5");   endtask
  task automatic t_small;
    run0(1, 1, 1'b0, 5, "R11");
    run0(0, 0, 1'b0, 5, "R11");
    run0(0, 3, 1'b0, 5, "R11");
  endtask

  task automatic t_indep;
    @(negedge clk);
    en0 = 0; en1 = 0;
    period0 = 4; duty0 = 1; pol0 = 0;
    period1 = 7; duty1 = 5; pol1 = 1;
    repeat (2) @(negedge clk);
    en0 = 1; en1 = 1;
    @(negedge clk);
    for (int k = 0; k < 28; k++) begin
      check(pwm_out0, expect_out(k, 4, 1, 1'b0), "R6", $sformatf("ch0 cycle %0d", k));
      check(pwm_out1, expect_out(k, 7, 5, 1'b1), "R6", $sformatf("ch1 cycle %0d", k));
      @(negedge clk);
    end
    en0 = 0; en1 = 0; pol1 = 0;
  endtask

  task automatic t_shadow;
    start0(10, 3, 1'b0);
    for (int k = 0; k < 34; k++) begin
      if (k < 10)
        check(pwm_out0, expect_out(k, 10, 3, 1'b0), "R7", $sformatf("old values cycle %0d", k));
      else
        check(pwm_out0, expect_out(k - 10, 12, 7, 1'b0), "R7", $sformatf("new values cycle %0d", k));
      if (k == 4) begin
        duty0 = 7; period0 = 12;
      end
      @(negedge clk);
    end
    en0 = 0;
  endtask

  task automatic t_join;
    @(negedge clk);
    en0 = 0; en1 = 1; join_en = 1;
    period1 = 8'h01; period0 = 8'h2C;
    duty1 = 8'h01; duty0 = 8'h00;
    pol0 = 0; pol1 = 1;
    repeat (2) @(negedge clk);
    en0 = 1;
    @(negedge clk);
    for (int k = 0; k < 600; k++) begin
      check(pwm_out0, expect_out(k, 300, 256, 1'b0), "R8", $sformatf("fused cycle %0d", k));
      check(pwm_out1, 1'b1, "R9", $sformatf("out1 fused cycle %0d", k));
      @(negedge clk);
    end
    en0 = 0; en1 = 0; join_en = 0; pol1 = 0;
  endtask

  task automatic t_enable;
    start0(10, 5, 1'b1);
    for (int k = 0; k < 3; k++) begin
      check(pwm_out0, expect_out(k, 10, 5, 1'b1), "R10", $sformatf("before disable cycle %0d", k));
      @(negedge clk);
    end
    en0 = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(pwm_out0, 1'b1, "R10", $sformatf("disabled cycle %0d", k));
    end
    en0 = 1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      check(pwm_out0, expect_out(k, 10, 5, 1'b1), "R10", $sformatf("restart cycle %0d", k));
      @(negedge clk);
    end
    en0 = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_zero();
    t_full();
    t_pol();
    t_small();
    t_indep();
    t_shadow();
    t_join();
    t_enable();
    summary();
    $finish;
  end
endmodule